// File: doc/BRIEF.md
# Per-Lane Selectable Event Counter

This block holds one 32-bit counter that tallies a single chosen event on a single chosen lane of a multi-lane serial link controller. The event sources arrive as a flat bus of single-cycle pulses, one bit for each combination of event group, event number and lane. Software programs a control word that names the group, the event within the group and the lane, and that carries a three-bit enable code and a two-bit clear code. The running total is read back from a separate data word.

The selection is a pure multiplexer in front of the counter: reprogramming it never resets the total, so software that wants a fresh measurement asks for a clear in the same or a later control write. Selections that name a group, event or lane the instance was not built with select nothing and leave the total untouched.

Top module: `lane_evt_counter`

## Requirements
- R1: After reset the count reads 0, the control word reads 0 (counting disabled, all selections 0), and any offset other than 0x8 and 0xC reads 0.
- R2: A write to offset 0x8 stores the group number from bits 27:24, the event number from bits 23:16 and the lane from bits 11:8; reading offset 0x8 returns them in those same positions, with bits 6:0 reading 0.
- R3: Enable code 0x3 in bits 4:2 switches counting on and code 0x1 switches it off; bit 7 of the control word reads 1 exactly while counting is on.
- R4: Any other enable code (0x0, 0x2, 0x4 to 0x7) leaves the on/off state as it was.
- R5: While counting is on, each clock cycle in which the selected event bit (index ((group*EVENTS_PER_GROUP)+event)*NUM_LANES+lane) is high adds 1 to the count read at offset 0xC; pulses on all other bits add nothing.
- R6: While counting is off the count does not change, whatever the event bus does.
- R7: Clear code 0x1 in bits 1:0 of a control write sets the count to 0 at that clock edge; clear codes 0x0, 0x2 and 0x3 leave the count unchanged.
- R8: When a clear and a counted pulse fall in the same cycle, the count reads 0 afterwards.
- R9: Changing the group, event or lane selection without a clear keeps the count as it was.
- R10: A selection whose group, event or lane is beyond the built sizes adds no counts.
- R11: The count increments by exactly 1 per counted cycle and wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| evt_i | input | NUM_GROUPS*EVENTS_PER_GROUP*NUM_LANES | Event pulses, one bit per group/event/lane |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write offset |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | ADDR_W | Register read offset |
| rd_data_o | output | 32 | Register read data, combinational from rd_addr_i |

## Verification
A control write carrying clear code 0x1 and a high pulse on the selected event bit can land on the same clock edge, and so can a selection change and a counted pulse. The bench provokes the first by raising the selected bit and issuing the clearing write in one cycle with counting on, then judges that the count reads 0 rather than 1. For the second it counts a known number of pulses, rewrites the lane while pulses continue on the old lane, and checks that the total equals the pulses seen under the old selection only.

// File: rtl/lec_pkg.sv
package lec_pkg;

    localparam int REG_W         = 32;
    localparam int CTRL_OFFSET   = 'h08;
    localparam int DATA_OFFSET   = 'h0C;

    localparam int GRP_LSB       = 24;
    localparam int EVT_LSB       = 16;
    localparam int LANE_LSB      = 8;
    localparam int STATUS_BIT    = 7;
    localparam int ENA_LSB       = 2;
    localparam int CLR_LSB       = 0;

    localparam logic [2:0] ENA_CODE_ON  = 3'h3;
    localparam logic [2:0] ENA_CODE_OFF = 3'h1;
    localparam logic [1:0] CLR_CODE_GO  = 2'h1;

    typedef struct packed {
        logic [3:0] grp;
        logic [7:0] evt;
        logic [3:0] lane;
        logic       active;
    } sel_state_t;

    typedef struct packed {
        logic [3:0] grp;
        logic [7:0] evt;
        logic [3:0] lane;
        logic [2:0] ena_code;
        logic [1:0] clr_code;
    } ctrl_word_t;

    function automatic ctrl_word_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_word_t c;
        c.grp      = w[GRP_LSB +: 4];
        c.evt      = w[EVT_LSB +: 8];
        c.lane     = w[LANE_LSB +: 4];
        c.ena_code = w[ENA_LSB +: 3];
        c.clr_code = w[CLR_LSB +: 2];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_status(input sel_state_t s);
        logic [REG_W-1:0] w;
        w                 = '0;
        w[GRP_LSB +: 4]   = s.grp;
        w[EVT_LSB +: 8]   = s.evt;
        w[LANE_LSB +: 4]  = s.lane;
        w[STATUS_BIT]     = s.active;
        return w;
    endfunction

endpackage

// File: rtl/lec_ctrl_regs.sv
module lec_ctrl_regs
    import lec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                wr_en_i,
    input  logic [ADDR_W-1:0]   wr_addr_i,
    input  logic [REG_W-1:0]    wr_data_i,
    output sel_state_t          state_o,
    output logic                clear_o
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFFSET);

    ctrl_word_t  wr_word;
    logic        ctrl_hit;
    sel_state_t  state_q;

    always_comb begin
        wr_word  = unpack_ctrl(wr_data_i);
        ctrl_hit = wr_en_i && (wr_addr_i == CTRL_ADDR);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= '0;
        end else if (ctrl_hit) begin
            state_q.grp  <= wr_word.grp;
            state_q.evt  <= wr_word.evt;
            state_q.lane <= wr_word.lane;
            if (wr_word.ena_code == ENA_CODE_ON) begin
                state_q.active <= 1'b1;
            end else if (wr_word.ena_code == ENA_CODE_OFF) begin
                state_q.active <= 1'b0;
            end
        end
    end

    assign state_o = state_q;
    assign clear_o = ctrl_hit && (wr_word.clr_code == CLR_CODE_GO);

endmodule

// File: rtl/lec_event_mux.sv
module lec_event_mux
    import lec_pkg::*;
#(
    parameter int NUM_GROUPS       = 2,
    parameter int EVENTS_PER_GROUP = 4,
    parameter int NUM_LANES        = 4
) (
    input  logic [NUM_GROUPS*EVENTS_PER_GROUP*NUM_LANES-1:0] evt_i,
    input  sel_state_t                                        state_i,
    output logic                                              hit_o
);

    localparam int GRP_SPAN = EVENTS_PER_GROUP * NUM_LANES;
    localparam int IDX_W    = (GRP_SPAN > 1) ? $clog2(GRP_SPAN) : 1;

    logic             in_range;
    logic [IDX_W-1:0] local_idx;
    logic [NUM_GROUPS-1:0] grp_hit;

    always_comb begin
        in_range  = (int'(state_i.evt) < EVENTS_PER_GROUP) &&
                    (int'(state_i.lane) < NUM_LANES);
        local_idx = IDX_W'(int'(state_i.evt) * NUM_LANES + int'(state_i.lane));
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
        logic [GRP_SPAN-1:0] slice;
        assign slice = evt_i[g*GRP_SPAN +: GRP_SPAN];
        always_comb begin
            grp_hit[g] = 1'b0;
            if (in_range && (int'(state_i.grp) == g)) begin
                grp_hit[g] = slice[local_idx];
            end
        end
    end

    assign hit_o = |grp_hit;

endmodule

// File: rtl/lec_count.sv
module lec_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clear_i,
    input  logic             active_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] count_o
);

    logic [CNT_W-1:0] count_q;

    always_ff @(posedge clk_i) begin
        if (rst_i || clear_i) begin
            count_q <= '0;
        end else if (active_i && hit_i) begin
            count_q <= count_q + CNT_W'(1);
        end
    end

    assign count_o = count_q;

endmodule

// File: rtl/lane_evt_counter.sv
module lane_evt_counter
    import lec_pkg::*;
#(
    parameter int NUM_GROUPS       = 2,
    parameter int EVENTS_PER_GROUP = 4,
    parameter int NUM_LANES        = 4,
    parameter int ADDR_W           = 8
) (
    input  logic                                              clk_i,
    input  logic                                              rst_i,
    input  logic [NUM_GROUPS*EVENTS_PER_GROUP*NUM_LANES-1:0]  evt_i,
    input  logic                                              wr_en_i,
    input  logic [ADDR_W-1:0]                                 wr_addr_i,
    input  logic [31:0]                                       wr_data_i,
    input  logic [ADDR_W-1:0]                                 rd_addr_i,
    output logic [31:0]                                       rd_data_o
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_OFFSET);
    localparam logic [ADDR_W-1:0] DATA_ADDR = ADDR_W'(DATA_OFFSET);

    sel_state_t        sel_state;
    logic              clear_req;
    logic              evt_hit;
    logic [REG_W-1:0]  count_val;

    lec_ctrl_regs #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .state_o   (sel_state),
        .clear_o   (clear_req)
    );

    lec_event_mux #(
        .NUM_GROUPS       (NUM_GROUPS),
        .EVENTS_PER_GROUP (EVENTS_PER_GROUP),
        .NUM_LANES        (NUM_LANES)
    ) mux_i (
        .evt_i   (evt_i),
        .state_i (sel_state),
        .hit_o   (evt_hit)
    );

    lec_count #(.CNT_W(REG_W)) cnt_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .clear_i  (clear_req),
        .active_i (sel_state.active),
        .hit_i    (evt_hit),
        .count_o  (count_val)
    );

    always_comb begin
        if (rd_addr_i == CTRL_ADDR) begin
            rd_data_o = pack_status(sel_state);
        end else if (rd_addr_i == DATA_ADDR) begin
            rd_data_o = count_val;
        end else begin
            rd_data_o = '0;
        end
    end

endmodule

// File: rtl/lec_checker.sv
module lec_checker
    import lec_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic [31:0]       wr_data_i,
    input logic              active,
    input logic              hit,
    input logic [31:0]       count
);

    logic       ctrl_wr;
    logic       clr_wr;
    logic [2:0] ena_f;

    assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_W'(CTRL_OFFSET));
    assign ena_f   = wr_data_i[ENA_LSB +: 3];
    assign clr_wr  = ctrl_wr && (wr_data_i[CLR_LSB +: 2] == CLR_CODE_GO);

    assert_enable_on_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_wr && ena_f == ENA_CODE_ON) |=> active);

    assert_enable_off_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_wr && ena_f == ENA_CODE_OFF) |=> !active);

    assert_enable_keep_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctrl_wr && ena_f != ENA_CODE_ON && ena_f != ENA_CODE_OFF) |=> (active == $past(active)));

    assert_hold_when_off_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!active && !clr_wr) |=> $stable(count));

    assert_clear_zero_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_wr |=> (count == 32'd0));

    assert_clear_wins_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (clr_wr && active && hit) |=> (count == 32'd0));

    assert_unit_step_R11: assert property (@(posedge clk_i) disable iff (rst_i)
        !clr_wr |=> (count == $past(count) || count == $past(count) + 32'd1));

    assert_counted_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!clr_wr && active && hit) |=> (count == $past(count) + 32'd1));

endmodule

bind lane_evt_counter lec_checker #(.ADDR_W(ADDR_W)) chk_i (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .active    (sel_state.active),
    .hit       (evt_hit),
    .count     (count_val)
);

// File: tb/lane_evt_counter_tb_top.sv
module lane_evt_counter_tb_top;

    localparam int NG  = 2;
    localparam int EPG = 4;
    localparam int NL  = 4;
    localparam int EW  = NG * EPG * NL;
    localparam logic [7:0] A_CTRL = 8'h08;
    localparam logic [7:0] A_DATA = 8'h0C;

    logic          clk = 1'b0;
    logic          rst;
    logic [EW-1:0] evt;
    logic          wr_en;
    logic [7:0]    wr_addr;
    logic [31:0]   wr_data;
    logic [7:0]    rd_addr;
    logic [31:0]   rd_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lane_evt_counter #(
        .NUM_GROUPS(NG), .EVENTS_PER_GROUP(EPG), .NUM_LANES(NL), .ADDR_W(8)
    ) dut_i (
        .clk_i(clk), .rst_i(rst), .evt_i(evt), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data)
    );

    function automatic logic [31:0] mk(int g, int e, int l, int en, int cl);
        return (32'(g) << 24) | (32'(e) << 16) | (32'(l) << 8) | (32'(en) << 2) | 32'(cl);
    endfunction

    function automatic int bit_of(int g, int e, int l);
        return ((g * EPG) + e) * NL + l;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_wr(logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic pulse(logic [EW-1:0] pat, int n);
        @(negedge clk);
        evt = pat;
        repeat (n) @(negedge clk);
        evt = '0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        reg_rd(A_DATA, d); check("R1 count", d, 0);
        reg_rd(A_CTRL, d); check("R1 ctrl", d, 0);
        reg_rd(8'h10, d);  check("R1 other offset", d, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        reg_wr(mk(1, 2, 3, 1, 0) | 32'h0000_0060);
        reg_rd(A_CTRL, d); check("R2 fields", d, 32'h0102_0300);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        reg_wr(mk(0, 0, 0, 3, 0));
        reg_rd(A_CTRL, d); check("R3 on status", d, 32'h80);
        for (int c = 0; c < 8; c++) begin
            if (c != 1 && c != 3) begin
                reg_wr(mk(0, 0, 0, c, 0));
                reg_rd(A_CTRL, d); check("R4 keep on", d, 32'h80);
            end
        end
        reg_wr(mk(0, 0, 0, 1, 0));
        reg_rd(A_CTRL, d); check("R3 off status", d, 32'h0);
        reg_wr(mk(0, 0, 0, 6, 0));
        reg_rd(A_CTRL, d); check("R4 keep off", d, 32'h0);
    endtask

    task automatic t_count();
        logic [31:0] d;
        logic [EW-1:0] others;
        int b;
        b = bit_of(1, 3, 2);
        reg_wr(mk(1, 3, 2, 3, 1));
        pulse(EW'(1) << b, 5);
        reg_rd(A_DATA, d); check("R5 five pulses", d, 5);
        others = ~(EW'(1) << b);
        pulse(others, 6);
        reg_rd(A_DATA, d); check("R5 other bits ignored", d, 5);
        pulse('1, 3);
        reg_rd(A_DATA, d); check("R5 all bits", d, 8);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        reg_wr(mk(1, 3, 2, 1, 0));
        pulse('1, 4);
        reg_rd(A_DATA, d); check("R6 off holds", d, 8);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin
            if (c != 1) begin
                reg_wr(mk(1, 3, 2, 0, c));
                reg_rd(A_DATA, d); check("R7 no clear", d, 8);
            end
        end
        reg_wr(mk(1, 3, 2, 0, 1));
        reg_rd(A_DATA, d); check("R7 clear", d, 0);
    endtask

    task automatic t_clear_wins();
        logic [31:0] d;
        int b;
        b = bit_of(0, 1, 1);
        reg_wr(mk(0, 1, 1, 3, 0));
        pulse(EW'(1) << b, 3);
        reg_rd(A_DATA, d); check("R8 pre count", d, 3);
        @(negedge clk);
        evt = EW'(1) << b;
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = mk(0, 1, 1, 0, 1);
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        reg_rd(A_DATA, d); check("R8 clear beats pulse", d, 0);
    endtask

    task automatic t_reselect();
        logic [31:0] d;
        int b0, b1;
        b0 = bit_of(0, 2, 0);
        b1 = bit_of(0, 2, 3);
        reg_wr(mk(0, 2, 0, 3, 1));
        pulse(EW'(1) << b0, 4);
        @(negedge clk);
        evt = EW'(1) << b0;
        wr_en = 1'b1; wr_addr = A_CTRL; wr_data = mk(0, 2, 3, 0, 0);
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        evt = '0;
        reg_rd(A_DATA, d); check("R9 kept after reselect", d, 5);
        pulse(EW'(1) << b1, 2);
        reg_rd(A_DATA, d); check("R9 counts new lane", d, 7);
    endtask

    task automatic t_absent();
        logic [31:0] d;
        reg_wr(mk(5, 0, 0, 3, 1));
        pulse('1, 4);
        reg_rd(A_DATA, d); check("R10 bad group", d, 0);
        reg_wr(mk(0, 9, 0, 0, 0));
        pulse('1, 4);
        reg_rd(A_DATA, d); check("R10 bad event", d, 0);
        reg_wr(mk(1, 0, 7, 0, 0));
        pulse('1, 4);
        reg_rd(A_DATA, d); check("R10 bad lane", d, 0);
        reg_wr(mk(1, 0, 3, 0, 0));
        pulse('1, 2);
        reg_rd(A_DATA, d); check("R11 unit steps", d, 2);
    endtask

    initial begin
        #800000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; evt = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_enable();
        t_count();
        t_disabled();
        t_clear();
        t_clear_wins();
        t_reselect();
        t_absent();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule